// File: doc/BRIEF.md
# Sequential Dual-Lane Multiply-Accumulate Reduction

This unit reduces two 128-bit vectors into a 64-bit accumulator. A start strobe captures both vectors, the incoming accumulator, a 16-bit byte-lane enable mask and the mode controls. The unit then walks the elements one per clock: eight 16-bit elements or four 32-bit elements. Each enabled element adds the product of its `vec_m` element and a `vec_n` element to the running sum. The `vec_n` element is the one in the same position, or, in exchange mode, its even/odd partner. In subtract mode the products of odd elements are subtracted. Products are sign- or zero-extended as selected, and the sum wraps modulo 2^64.

In rounding-high mode, available for 32-bit elements only, the accumulator is kept as a 72-bit sum with eight guard bits below it. Each active product is followed by a rounding increment of 128. The result is the upper 64 bits of that sum. A mode combination outside the supported set completes at once with an error flag and leaves the output untouched.

The controller has three states. IDLE waits for `start`. RUN processes one element per clock. DONE shows the result for one cycle. The transitions are:
- IDLE to RUN on a valid start.
- IDLE to DONE on a start with an illegal mode.
- RUN to RUN while elements remain.
- RUN to DONE after the last element.
- DONE to IDLE unconditionally.

Top module: `dmac_long`

## Requirements
- R1: A valid start completes in the fixed element count. `done` is high for exactly one cycle, 8 clock edges (16-bit) or 4 clock edges (32-bit) after the edge that samples `start`. `busy` is high between these two points and never together with `done`.
- R2: Element e occupies bits [e*W +: W] of each vector (W = 16 or 32). Without exchange, element e contributes `vec_n[e] * vec_m[e]`.
- R3: In exchange mode, an even element e uses `vec_n[e+1]` and an odd element e uses `vec_n[e-1]`. Each is multiplied by `vec_m[e]`.
- R4: With `sub_odd` set, products of even elements are added and products of odd elements are subtracted.
- R5: Element e contributes only when `lane_mask[e*W/8]` is 1. The other mask bits have no effect.
- R6: With `is_signed` = 1, operands are sign-extended; with `is_signed` = 0 they are zero-extended. The products are exact, and the sum wraps modulo 2^64.
- R7: In rounding-high mode, the sum starts as `{acc_in, 8'h00}` in 72 bits. Each active product is followed by an addition of 128. `acc_out` is bits 71:8 of the final sum.
- R8: A start is illegal when `round_high` is used with 16-bit elements, or when `is_signed` = 0 is used with `exchange` or `sub_odd`. An illegal start raises `done` and `err` in the next cycle and leaves `acc_out` unchanged. Legal operations finish with `err` = 0.
- R9: A `start` that arrives while an operation is running is ignored.
- R10: After reset, `acc_out` = 0 and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures operands and mode; starts an operation |
| vec_n | input | 128 | First operand vector |
| vec_m | input | 128 | Second operand vector |
| acc_in | input | 64 | Incoming accumulator |
| lane_mask | input | 16 | Byte-lane enable mask |
| elem_wide | input | 1 | 1: 32-bit elements, 0: 16-bit elements |
| is_signed | input | 1 | Sign-extend operands when 1 |
| exchange | input | 1 | Cross even and odd `vec_n` elements |
| sub_odd | input | 1 | Subtract odd-element products |
| round_high | input | 1 | 72-bit rounding-high accumulation |
| acc_out | output | 64 | Result accumulator, valid from `done` on |
| busy | output | 1 | Elements being processed |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal mode, valid with `done` |

## Verification
A table of fourteen mode and mask patterns is run against a reference sum built from the requirements. The patterns cover the following, and each isolates one effect:
- Plain signed and unsigned runs at both element widths separate sign extension from zero extension.
- Exchange-only and subtract-only runs show which `vec_n` element is paired with which, and which products change sign.
- Rounding-high runs distinguish per-product rounding from a single final rounding.
- Sparse and empty masks show that only the lowest byte lane of each element is consulted.

Directed cases then cover:
- the reset state;
- each illegal mode, with the output held;
- a start arriving mid-operation;
- a hand-worked rounding example;
- a worst-case unsigned run that forces 64-bit wraparound.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dmac_state_e;

    typedef struct packed {
        logic wide;
        logic sgn;
        logic xchg;
        logic sub_odd;
        logic rnd;
    } dmac_mode_t;

endpackage

// File: rtl/dmac_lane_pick.sv
module dmac_lane_pick #(
    parameter int VEC_W = 128,
    parameter int OP_W  = 32,
    localparam int N_HALF  = VEC_W / (OP_W / 2),
    localparam int N_FULL  = VEC_W / OP_W,
    localparam int IDX_W   = $clog2(N_HALF),
    localparam int FIDX_W  = $clog2(N_FULL),
    localparam int MASK_W  = VEC_W / 8
) (
    input  logic [VEC_W-1:0]  vec_n,
    input  logic [VEC_W-1:0]  vec_m,
    input  logic [MASK_W-1:0] mask,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wide,
    input  logic              xchg,
    output logic [OP_W-1:0]   op_n,
    output logic [OP_W-1:0]   op_m,
    output logic              active
);
    localparam int HW = OP_W / 2;

    logic [OP_W-1:0] full_n [N_FULL];
    logic [OP_W-1:0] full_m [N_FULL];
    logic [HW-1:0]   half_n [N_HALF];
    logic [HW-1:0]   half_m [N_HALF];

    genvar g;
    generate
        for (g = 0; g < N_FULL; g++) begin : g_full
            assign full_n[g] = vec_n[g*OP_W +: OP_W];
            assign full_m[g] = vec_m[g*OP_W +: OP_W];
        end
        for (g = 0; g < N_HALF; g++) begin : g_half
            assign half_n[g] = vec_n[g*HW +: HW];
            assign half_m[g] = vec_m[g*HW +: HW];
        end
    endgenerate

    logic [IDX_W-1:0] n_idx;

    always_comb begin
        n_idx = xchg ? (idx ^ IDX_W'(1)) : idx;
        if (wide) begin
            op_n   = full_n[n_idx[FIDX_W-1:0]];
            op_m   = full_m[idx[FIDX_W-1:0]];
            active = mask[{idx[FIDX_W-1:0], 2'b00}];
        end else begin
            op_n   = {{HW{1'b0}}, half_n[n_idx]};
            op_m   = {{HW{1'b0}}, half_m[idx]};
            active = mask[{idx, 1'b0}];
        end
    end

endmodule

// File: rtl/dmac_mult.sv
module dmac_mult #(
    parameter int OP_W = 32,
    localparam int PROD_W = 2 * OP_W + 2
) (
    input  logic [OP_W-1:0]          a,
    input  logic [OP_W-1:0]          b,
    input  logic                     half,
    input  logic                     sgn,
    output logic signed [PROD_W-1:0] prod
);
    localparam int HW = OP_W / 2;

    logic signed [OP_W:0] a_x;
    logic signed [OP_W:0] b_x;

    always_comb begin
        if (half) begin
            a_x = {{(HW+1){sgn & a[HW-1]}}, a[HW-1:0]};
            b_x = {{(HW+1){sgn & b[HW-1]}}, b[HW-1:0]};
        end else begin
            a_x = {sgn & a[OP_W-1], a};
            b_x = {sgn & b[OP_W-1], b};
        end
    end

    assign prod = a_x * b_x;

endmodule

// File: rtl/dmac_long.sv
module dmac_long
    import dmac_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int ACC_W   = 64,
    parameter int GUARD_W = 8,
    parameter int OP_W    = 32,
    localparam int N_HALF = VEC_W / (OP_W / 2),
    localparam int N_FULL = VEC_W / OP_W,
    localparam int IDX_W  = $clog2(N_HALF),
    localparam int MASK_W = VEC_W / 8,
    localparam int SUM_W  = ACC_W + GUARD_W,
    localparam int PROD_W = 2 * OP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  vec_n,
    input  logic [VEC_W-1:0]  vec_m,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic              elem_wide,
    input  logic              is_signed,
    input  logic              exchange,
    input  logic              sub_odd,
    input  logic              round_high,
    output logic [ACC_W-1:0]  acc_out,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [SUM_W-1:0] RND_INC   = SUM_W'(1) << (GUARD_W - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(N_HALF - 1);
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(N_FULL - 1);

    dmac_state_e       state_q, state_d;
    dmac_mode_t        mode_q;
    logic [VEC_W-1:0]  n_q, m_q;
    logic [MASK_W-1:0] mask_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SUM_W-1:0]  sum_q;
    logic              err_q;

    logic                     bad_mode;
    logic                     last_elem;
    logic [OP_W-1:0]          op_n, op_m;
    logic                     lane_act;
    logic signed [PROD_W-1:0] prod;
    logic [SUM_W-1:0]         prod_x, step, rnd_add;

    assign bad_mode  = (round_high && !elem_wide) ||
                       (!is_signed && (exchange || sub_odd));
    assign last_elem = idx_q == (mode_q.wide ? LAST_FULL : LAST_HALF);

    dmac_lane_pick #(.VEC_W(VEC_W), .OP_W(OP_W)) pick_i (
        .vec_n  (n_q),
        .vec_m  (m_q),
        .mask   (mask_q),
        .idx    (idx_q),
        .wide   (mode_q.wide),
        .xchg   (mode_q.xchg),
        .op_n   (op_n),
        .op_m   (op_m),
        .active (lane_act)
    );

    dmac_mult #(.OP_W(OP_W)) mult_i (
        .a    (op_n),
        .b    (op_m),
        .half (!mode_q.wide),
        .sgn  (mode_q.sgn),
        .prod (prod)
    );

    always_comb begin
        prod_x  = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
        step    = (idx_q[0] && mode_q.sub_odd) ? (~prod_x + SUM_W'(1)) : prod_x;
        rnd_add = mode_q.rnd ? RND_INC : '0;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = bad_mode ? ST_DONE : ST_RUN;
            ST_RUN:  if (last_elem) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            n_q    <= '0;
            m_q    <= '0;
            mask_q <= '0;
            idx_q  <= '0;
            sum_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= bad_mode;
                        if (!bad_mode) begin
                            mode_q <= '{wide: elem_wide, sgn: is_signed, xchg: exchange,
                                        sub_odd: sub_odd, rnd: round_high};
                            n_q    <= vec_n;
                            m_q    <= vec_m;
                            mask_q <= lane_mask;
                            idx_q  <= '0;
                            sum_q  <= round_high ? {acc_in, {GUARD_W{1'b0}}}
                                                 : {{GUARD_W{1'b0}}, acc_in};
                        end
                    end
                end
                ST_RUN: begin
                    if (lane_act) sum_q <= sum_q + step + rnd_add;
                    idx_q <= idx_q + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = state_q == ST_RUN;
        done    = state_q == ST_DONE;
        err     = done && err_q;
        acc_out = mode_q.rnd ? sum_q[SUM_W-1:GUARD_W] : sum_q[ACC_W-1:0];
    end

endmodule

// File: rtl/dmac_long_chk.sv
module dmac_long_chk #(
    parameter int ACC_W   = 64,
    parameter int MAX_RUN = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [ACC_W-1:0] acc_out
);
    logic [$clog2(MAX_RUN+2)-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R1
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < MAX_RUN));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(acc_out));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind dmac_long dmac_long_chk #(.ACC_W(ACC_W), .MAX_RUN(N_HALF)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .acc_out (acc_out)
);

// File: tb/dmac_long_tb_top.sv
`timescale 1ns/1ps
module dmac_long_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] vec_n = '0, vec_m = '0;
    logic [63:0]  acc_in = '0;
    logic [15:0]  lane_mask = '0;
    logic         elem_wide = 0, is_signed = 0, exchange = 0, sub_odd = 0, round_high = 0;
    logic [63:0]  acc_out;
    logic         busy, done, err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dmac_long dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_n(vec_n), .vec_m(vec_m),
        .acc_in(acc_in), .lane_mask(lane_mask), .elem_wide(elem_wide),
        .is_signed(is_signed), .exchange(exchange), .sub_odd(sub_odd),
        .round_high(round_high), .acc_out(acc_out), .busy(busy), .done(done), .err(err)
    );

    // table entry: {wide, sgn, xchg, sub, rnd, mask[15:0], seed[7:0]}
    localparam int NVEC = 14;
    localparam logic [28:0] VEC_TAB [NVEC] = '{
        {5'b01000, 16'hFFFF, 8'h01},
        {5'b00000, 16'hFFFF, 8'h02},
        {5'b11000, 16'hFFFF, 8'h03},
        {5'b10000, 16'hFFFF, 8'h04},
        {5'b01100, 16'hFFFF, 8'h05},
        {5'b11100, 16'hFFFF, 8'h06},
        {5'b01010, 16'hFFFF, 8'h07},
        {5'b11110, 16'hFFFF, 8'h08},
        {5'b11001, 16'hFFFF, 8'h09},
        {5'b10001, 16'hFFFF, 8'h0A},
        {5'b11111, 16'h0F0F, 8'h0B},
        {5'b01000, 16'h5A3C, 8'h0C},
        {5'b10000, 16'h00F1, 8'h0D},
        {5'b01110, 16'h0000, 8'h0E}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] gen_vec(input logic [7:0] seed, input int salt);
        logic [127:0] v;
        logic [31:0]  w;
        for (int k = 0; k < 4; k++) begin
            w = (32'(seed) * 32'h9E3779B1) ^ (32'(k + salt * 4 + 1) * 32'h7F4A7C15);
            w = w ^ (w >> 13) ^ (w << 7);
            v[k*32 +: 32] = w;
        end
        return v;
    endfunction

    function automatic logic [63:0] ref_acc(input logic [127:0] n, input logic [127:0] m,
                                            input logic [63:0] acc, input logic [15:0] mk,
                                            input logic [4:0] md);
        logic signed [71:0] s, a, b, p;
        logic [31:0] ra, rb;
        int ne, w, ni;
        logic wide, sgn, xchg, sub, rnd;
        {wide, sgn, xchg, sub, rnd} = md;
        ne = wide ? 4 : 8;
        w  = wide ? 32 : 16;
        s  = rnd ? {acc, 8'h00} : {8'h00, acc};
        for (int e = 0; e < ne; e++) begin
            if (mk[e * (w / 8)]) begin
                ni = xchg ? (e ^ 1) : e;
                ra = 32'(n >> (ni * w));
                rb = 32'(m >> (e * w));
                if (!wide) begin
                    ra[31:16] = '0;
                    rb[31:16] = '0;
                end
                a = 72'(ra);
                b = 72'(rb);
                if (sgn && ra[w-1]) a = a - (72'sd1 <<< w);
                if (sgn && rb[w-1]) b = b - (72'sd1 <<< w);
                p = a * b;
                if (sub && (e % 2 == 1)) s = s - p;
                else                     s = s + p;
                if (rnd) s = s + 72'sd128;
            end
        end
        return rnd ? s[71:8] : s[63:0];
    endfunction

    task automatic run_op(input logic [127:0] n, input logic [127:0] m, input logic [63:0] acc,
                          input logic [15:0] mk, input logic [4:0] md, output int cyc);
        @(negedge clk);
        vec_n = n; vec_m = m; acc_in = acc; lane_mask = mk;
        {elem_wide, is_signed, exchange, sub_odd, round_high} = md;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic [127:0] n, m;
        logic [63:0]  acc, exp, held;
        logic [4:0]   md;
        logic [15:0]  mk;
        string        tag;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 acc_out", acc_out, 64'd0);
        check("R10 flags", {61'd0, busy, done, err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            md  = VEC_TAB[i][28:24];
            mk  = VEC_TAB[i][23:8];
            n   = gen_vec(VEC_TAB[i][7:0], 0);
            m   = gen_vec(VEC_TAB[i][7:0], 1);
            acc = {n[31:0], m[63:32]};
            exp = ref_acc(n, m, acc, mk, md);
            run_op(n, m, acc, mk, md, cyc);
            if (md[0])             tag = "R7";
            else if (mk != 16'hFFFF) tag = "R5";
            else if (md[1])        tag = "R4";
            else if (md[2])        tag = "R3";
            else if (!md[3])       tag = "R6";
            else                   tag = "R2";
            check(tag, acc_out, exp);
            check("R1 latency", 64'(cyc), md[4] ? 64'd4 : 64'd8);
            check("R8 err low on legal mode", 64'(err), 64'd0);
        end

        // R7: hand-worked rounding case: (5<<8) + 0x4000 + 128 = 17792, >>8 = 69
        run_op(128'h80, 128'h80, 64'd5, 16'h0001, 5'b11001, cyc);
        check("R7 hand", acc_out, 64'd69);

        // R6: unsigned worst case wraps modulo 2^64
        n = '1;
        exp = ref_acc(n, n, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 5'b10000);
        run_op(n, n, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 5'b10000, cyc);
        check("R6 wrap", acc_out, exp);
        check("R6 wrap literal", acc_out, 64'hFFFF_FFF8_0000_0003);

        // R8: illegal modes
        held = acc_out;
        run_op(gen_vec(8'h21, 0), gen_vec(8'h22, 0), 64'h1234, 16'hFFFF, 5'b01001, cyc);
        check("R8 rnd16 latency", 64'(cyc), 64'd0);
        check("R8 rnd16 err", 64'(err), 64'd1);
        check("R8 rnd16 hold", acc_out, held);
        run_op(gen_vec(8'h23, 0), gen_vec(8'h24, 0), 64'h5678, 16'hFFFF, 5'b10100, cyc);
        check("R8 unsigned exchange err", 64'(err), 64'd1);
        check("R8 unsigned exchange hold", acc_out, held);
        run_op(gen_vec(8'h25, 0), gen_vec(8'h26, 0), 64'h9ABC, 16'hFFFF, 5'b00010, cyc);
        check("R8 unsigned subtract err", 64'(err), 64'd1);
        @(negedge clk);
        check("R8 unsigned subtract hold", acc_out, held);

        // R9: start while running is ignored
        n   = gen_vec(8'h31, 0);
        m   = gen_vec(8'h31, 1);
        exp = ref_acc(n, m, 64'h77, 16'hFFFF, 5'b01000);
        @(negedge clk);
        vec_n = n; vec_m = m; acc_in = 64'h77; lane_mask = 16'hFFFF;
        {elem_wide, is_signed, exchange, sub_odd, round_high} = 5'b01000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) begin
                vec_n = '1; acc_in = 64'hDEAD; elem_wide = 1'b1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check("R9 result", acc_out, exp);
        check("R9 latency", 64'(cyc), 64'd8);
        @(negedge clk);
        check("R9 no restart", 64'(busy), 64'd0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule